// File: doc/BRIEF.md
# Link Controller Online/Offline Handshake Unit

This unit brings a storage link controller online or takes it offline when software asks. Software writes a level request into a control register. The unit answers through a separate status flag, which changes only once the transition has actually finished. Between request and answer a small state machine walks through four states: OFFLINE, GOING_ONLINE, ONLINE and DRAINING. A counter follows how many commands the command engine has issued and not yet completed, using one-cycle issue and completion pulses.

An offline request does not take effect while commands remain outstanding. The unit waits in DRAINING until the count reaches zero. If software sets the request again before that, the offline request is withdrawn. A force condition from the link side skips the wait. When its status flag is set at the moment the request is cleared, the unit drops offline at once and discards the count. The unit also holds a 4-bit port-multiplier target. It tags every accepted command with that target, and this field should stay zero when a device is attached directly.

Top module: `ctl_online_mgr`

State transitions, named as used below:
- T_UP: OFFLINE→GOING_ONLINE when the request bit is 1.
- T_ARRIVE: GOING_ONLINE→ONLINE, always after one cycle.
- T_DROP: ONLINE→OFFLINE when the request is 0 and either the force flag is set or the count is zero.
- T_WAIT: ONLINE→DRAINING when the request is 0, the force flag is clear and the count is nonzero.
- T_CANCEL: DRAINING→ONLINE when the request is 1 again.
- T_EMPTY: DRAINING→OFFLINE once the count is zero.

## Requirements
- R1: After reset, the control, status and target registers all read 0, the unit is OFFLINE and `link_online` is 0.
- R2: After control bit 0 is written to 1 while OFFLINE, `link_online` and status bit 0 are still 0 one edge after the write (GOING_ONLINE) and are 1 from the second edge.
- R3: Clearing control bit 0 while ONLINE with no outstanding command clears `link_online` one edge after the write.
- R4: Clearing control bit 0 while commands are outstanding and the force flag is 0 keeps `link_online` at 1 until the count reaches zero. `link_online` falls one edge after the count reaches zero.
- R5: Clearing control bit 0 while status bit 1 (force flag, a registered copy of `force_ok_i`) is 1 takes the unit offline one edge after the write and clears the count, whatever the count was.
- R6: Setting control bit 0 again while DRAINING returns the unit to ONLINE, `link_online` stays 1 throughout, and new issues are accepted again.
- R7: An accepted issue pulse raises the count by 1. A completion pulse lowers it by 1. An accepted issue together with a completion leaves it unchanged.
- R8: The count never exceeds DEPTH (32). An issue while the count is DEPTH is rejected and the count stays DEPTH. A completion at count 0 leaves it at 0.
- R9: An issue pulse in any state other than ONLINE gives an `issue_err` pulse on the next cycle and leaves the count unchanged.
- R10: The target register (address 2) stores write-data bits 3:0. Bits 31:4 read as 0, and writes to them are ignored.
- R11: Each accepted issue gives an `issue_ack` pulse on the next cycle, with `issue_pmp` equal to the target register value when the issue happened.
- R12: Register map. Address 0 is control, bit 0 the request. Address 1 is status: bit 0 online, bit 1 force flag, bits 13:8 the count. Address 3 reads 0. Writes to status are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| force_ok_i | input | 1 | Link-side condition that permits an immediate offline |
| cmd_issue | input | 1 | One-cycle command issue pulse |
| cmd_done | input | 1 | One-cycle command completion pulse |
| issue_ack | output | 1 | Issue accepted |
| issue_err | output | 1 | Issue rejected |
| issue_pmp | output | 4 | Target tag of the accepted command |
| link_online | output | 1 | Online status flag |

## Verification
The hardest states to reach are T_CANCEL and T_EMPTY. Both need the unit to sit in DRAINING, which means commands must already be outstanding when the request is cleared. The bench issues commands while ONLINE, clears the request, and waits one cycle so that the state change has landed. It then probes DRAINING by issuing a command that must be rejected. After that it either sets the request again, or retires the commands one at a time and watches the exact edge at which the online flag drops. Saturation is reached by filling the counter with 32 accepted issues before a 33rd.

// File: rtl/olm_pkg.sv
package olm_pkg;

    typedef enum logic [1:0] {
        ST_OFFLINE  = 2'd0,
        ST_GOING_ON = 2'd1,
        ST_ONLINE   = 2'd2,
        ST_DRAINING = 2'd3
    } olm_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_PMQ  = 2'd2;

    localparam int STAT_ON_BIT    = 0;
    localparam int STAT_FORCE_BIT = 1;
    localparam int STAT_CNT_LSB   = 8;

endpackage

// File: rtl/olm_regs.sv
module olm_regs
    import olm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PMP_W  = 4,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              force_ok_i,
    input  logic              online,
    input  logic [CNT_W-1:0]  cnt,
    output logic              ctrl_en,
    output logic              force_q,
    output logic [PMP_W-1:0]  pmq
);

    logic              ctrl_en_q;
    logic [PMP_W-1:0]  pmq_q;
    logic              force_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en_q <= 1'b0;
            pmq_q     <= '0;
            force_r   <= 1'b0;
        end else begin
            force_r <= force_ok_i;
            if (bus_we) begin
                unique case (bus_addr)
                    A_CTRL:  ctrl_en_q <= bus_wdata[0];
                    A_PMQ:   pmq_q     <= bus_wdata[PMP_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: bus_rdata[0] = ctrl_en_q;
            A_STAT: begin
                bus_rdata[STAT_ON_BIT]            = online;
                bus_rdata[STAT_FORCE_BIT]         = force_r;
                bus_rdata[STAT_CNT_LSB +: CNT_W]  = cnt;
            end
            A_PMQ:  bus_rdata[PMP_W-1:0] = pmq_q;
            default: ;
        endcase
    end

    assign ctrl_en = ctrl_en_q;
    assign force_q = force_r;
    assign pmq     = pmq_q;

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_PMQ) |-> (bus_rdata[DATA_W-1:PMP_W] == '0));

    assert_stat_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_STAT) |=> ($stable(ctrl_en_q) && $stable(pmq_q)));

endmodule

// File: rtl/olm_cmd_count.sv
module olm_cmd_count #(
    parameter int DEPTH = 32,
    parameter int PMP_W = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_issue,
    input  logic             cmd_done,
    input  logic             accept_ok,
    input  logic             flush,
    input  logic [PMP_W-1:0] pmq,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero,
    output logic             issue_ack,
    output logic             issue_err,
    output logic [PMP_W-1:0] issue_pmp
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_q;
    logic             full, empty, take, drop;
    logic             ack_q, err_q;
    logic [PMP_W-1:0] tag_q;

    always_comb begin
        full  = (cnt_q == CNT_MAX);
        empty = (cnt_q == '0);
        take  = cmd_issue && accept_ok && !full;
        drop  = cmd_done && !empty;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ack_q <= 1'b0;
            err_q <= 1'b0;
            tag_q <= '0;
        end else begin
            ack_q <= take;
            err_q <= cmd_issue && !take;
            if (take) tag_q <= pmq;
            if (flush) begin
                cnt_q <= '0;
            end else begin
                unique case ({take, drop})
                    2'b10:   cnt_q <= cnt_q + 1'b1;
                    2'b01:   cnt_q <= cnt_q - 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign cnt       = cnt_q;
    assign cnt_zero  = empty;
    assign issue_ack = ack_q;
    assign issue_err = err_q;
    assign issue_pmp = tag_q;

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && cmd_issue && !cmd_done && !flush) |=> (cnt_q == CNT_MAX && issue_err));

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !cmd_issue) |=> (cnt_q == '0));

    assert_reject_keeps_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && !accept_ok && !cmd_done && !flush) |=> ($stable(cnt_q) && issue_err));

    assert_ack_err_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_ack && issue_err));

endmodule

// File: rtl/olm_fsm.sv
module olm_fsm
    import olm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_en,
    input  logic force_q,
    input  logic cnt_zero,
    output logic online,
    output logic accept_ok,
    output logic flush
);

    olm_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFFLINE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFFLINE:  if (ctrl_en) st_d = ST_GOING_ON;
            ST_GOING_ON: st_d = ST_ONLINE;
            ST_ONLINE: begin
                if (!ctrl_en) begin
                    if (force_q || cnt_zero) st_d = ST_OFFLINE;
                    else                     st_d = ST_DRAINING;
                end
            end
            ST_DRAINING: begin
                if (ctrl_en)       st_d = ST_ONLINE;
                else if (cnt_zero) st_d = ST_OFFLINE;
            end
        endcase
    end

    always_comb begin
        online    = 1'b0;
        accept_ok = 1'b0;
        flush     = 1'b0;
        unique case (st_q)
            ST_OFFLINE:  ;
            ST_GOING_ON: ;
            ST_ONLINE: begin
                online    = 1'b1;
                flush     = !ctrl_en && force_q;
                accept_ok = !flush;
            end
            ST_DRAINING: online = 1'b1;
        endcase
    end

    assert_going_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GOING_ON) |=> (st_q == ST_ONLINE));

    assert_online_rise_from_going_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(online) |-> ($past(st_q) == ST_GOING_ON));

    assert_drain_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRAINING && !ctrl_en && !cnt_zero) |=> online);

    assert_force_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ONLINE && !ctrl_en && force_q) |=> (!online && cnt_zero));

    assert_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRAINING && ctrl_en) |=> (st_q == ST_ONLINE));

endmodule

// File: rtl/ctl_online_mgr.sv
module ctl_online_mgr
    import olm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PMP_W  = 4,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              force_ok_i,
    input  logic              cmd_issue,
    input  logic              cmd_done,
    output logic              issue_ack,
    output logic              issue_err,
    output logic [PMP_W-1:0]  issue_pmp,
    output logic              link_online
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             ctrl_en, force_q, online, accept_ok, flush, cnt_zero;
    logic [PMP_W-1:0] pmq;
    logic [CNT_W-1:0] cnt;

    olm_regs #(.DATA_W(DATA_W), .PMP_W(PMP_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .force_ok_i(force_ok_i),
        .online(online), .cnt(cnt), .ctrl_en(ctrl_en), .force_q(force_q), .pmq(pmq)
    );

    olm_cmd_count #(.DEPTH(DEPTH), .PMP_W(PMP_W), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .cmd_done(cmd_done),
        .accept_ok(accept_ok), .flush(flush), .pmq(pmq), .cnt(cnt),
        .cnt_zero(cnt_zero), .issue_ack(issue_ack), .issue_err(issue_err),
        .issue_pmp(issue_pmp)
    );

    olm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .force_q(force_q),
        .cnt_zero(cnt_zero), .online(online), .accept_ok(accept_ok), .flush(flush)
    );

    assign link_online = online;

endmodule

// File: tb/ctl_online_mgr_tb.sv
module ctl_online_mgr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        force_ok_i = 1'b0;
    logic        cmd_issue = 1'b0;
    logic        cmd_done = 1'b0;
    logic        issue_ack, issue_err, link_online;
    logic [3:0]  issue_pmp;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;

    typedef struct {
        bit       is_ack;
        bit [3:0] pmp;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    ctl_online_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .force_ok_i(force_ok_i),
        .cmd_issue(cmd_issue), .cmd_done(cmd_done), .issue_ack(issue_ack),
        .issue_err(issue_err), .issue_pmp(issue_pmp), .link_online(link_online)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
        bus_addr = a; #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // driver: pushes the expected outcome of each issue into the scoreboard
    task automatic issue(input bit ok, input logic [3:0] pmp);
        exp_t e;
        e.is_ack = ok; e.pmp = pmp;
        sb_q.push_back(e);
        cmd_issue = 1'b1;
        @(posedge clk); #1;
        cmd_issue = 1'b0;
    endtask

    task automatic done_pulse();
        cmd_done = 1'b1;
        @(posedge clk); #1;
        cmd_done = 1'b0;
    endtask

    function automatic logic [31:0] stat(input int c, input bit f, input bit on);
        return (32'(c) << 8) | (32'(f) << 1) | 32'(on);
    endfunction

    // monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (rst_n && (issue_ack || issue_err)) begin
            if (sb_q.size() == 0) begin
                check("R9/R11 unexpected response", {30'd0, issue_ack, issue_err}, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check("R9/R11 ack vs err", {31'd0, issue_ack}, {31'd0, e.is_ack});
                if (e.is_ack) check("R11 issue_pmp", {28'd0, issue_pmp}, {28'd0, e.pmp});
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd_check("R1 ctrl", 2'd0, 32'd0);
        rd_check("R1 stat", 2'd1, 32'd0);
        rd_check("R1 pmq", 2'd2, 32'd0);
        check("R1 link_online", {31'd0, link_online}, 32'd0);

        // R9 issue while OFFLINE
        issue(1'b0, 4'd0);
        tick(1);
        rd_check("R9 count unchanged offline", 2'd1, stat(0, 0, 0));

        // R10 target register, reserved bits ignored
        wr(2'd2, 32'hFFFF_FFF5);
        rd_check("R10 pmq reserved zero", 2'd2, 32'h5);
        // R12 status write ignored, unused address reads zero
        wr(2'd1, 32'hFFFF_FFFF);
        rd_check("R12 stat write ignored", 2'd1, stat(0, 0, 0));
        rd_check("R12 ctrl unaffected", 2'd0, 32'd0);
        rd_check("R12 addr3 zero", 2'd3, 32'd0);

        // R2 going online
        wr(2'd0, 32'h1);
        rd_check("R12 ctrl bit0", 2'd0, 32'h1);
        tick(1);
        check("R2 still offline in GOING_ONLINE", {31'd0, link_online}, 32'd0);
        tick(1);
        check("R2 online after second edge", {31'd0, link_online}, 32'd1);
        rd_check("R2 stat online", 2'd1, stat(0, 0, 1));

        // R7/R11 counting and tagging
        issue(1'b1, 4'd5); issue(1'b1, 4'd5); issue(1'b1, 4'd5);
        rd_check("R7 count 3", 2'd1, stat(3, 0, 1));
        wr(2'd2, 32'h9);
        cmd_done = 1'b1;
        issue(1'b1, 4'd9);
        cmd_done = 1'b0;
        rd_check("R7 simultaneous unchanged", 2'd1, stat(3, 0, 1));
        done_pulse();
        rd_check("R7 decrement", 2'd1, stat(2, 0, 1));

        // R4 draining, R9 reject in DRAINING, R6 cancel
        wr(2'd0, 32'h0);
        tick(1);
        issue(1'b0, 4'd0);
        tick(2);
        check("R4 online while draining", {31'd0, link_online}, 32'd1);
        rd_check("R9 count unchanged draining", 2'd1, stat(2, 0, 1));
        wr(2'd0, 32'h1);
        tick(1);
        check("R6 online after cancel", {31'd0, link_online}, 32'd1);
        issue(1'b1, 4'd9);
        rd_check("R6 accepts after cancel", 2'd1, stat(3, 0, 1));

        // R4 drop exactly one edge after the count empties
        wr(2'd0, 32'h0);
        done_pulse(); done_pulse(); done_pulse();
        check("R4 online at count zero edge", {31'd0, link_online}, 32'd1);
        tick(1);
        check("R4 offline after drain", {31'd0, link_online}, 32'd0);

        // R8 saturation
        wr(2'd0, 32'h1);
        tick(2);
        for (int i = 0; i < 32; i++) issue(1'b1, 4'd9);
        rd_check("R8 count full", 2'd1, stat(32, 0, 1));
        issue(1'b0, 4'd0);
        rd_check("R8 saturated", 2'd1, stat(32, 0, 1));

        // R5 forced offline
        force_ok_i = 1'b1;
        tick(1);
        rd_check("R12 force flag", 2'd1, stat(32, 1, 1));
        wr(2'd0, 32'h0);
        check("R5 still online at write edge", {31'd0, link_online}, 32'd1);
        tick(1);
        check("R5 forced offline", {31'd0, link_online}, 32'd0);
        rd_check("R5 count cleared", 2'd1, stat(0, 1, 0));

        // R3 offline with empty queue
        force_ok_i = 1'b0;
        wr(2'd0, 32'h1);
        tick(2);
        issue(1'b1, 4'd9);
        done_pulse();
        wr(2'd0, 32'h0);
        check("R3 online at write edge", {31'd0, link_online}, 32'd1);
        tick(1);
        check("R3 offline one edge later", {31'd0, link_online}, 32'd0);
        done_pulse();
        rd_check("R8 no underflow", 2'd1, stat(0, 0, 0));

        tick(3);
        check("R11 scoreboard drained", 32'(sb_q.size()), 32'd0);
        finish_run();
    end

endmodule